// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one DMA channel that carries a byte stream between memory and a single peripheral port. Software programs work through two descriptor slots. Each slot holds a start address and a byte count. While the channel drains one slot, software refills the other, so a long transfer runs without gaps. The channel takes the slots in turn. After finishing a slot it moves to the other one if that slot is armed.

A four-state sequencer has these states: idle, stall, on (one slot armed) and next (both slots armed). It drives a memory request handshake. Each accepted request moves one byte for one peripheral request. Three flags can raise the interrupt line: stall (the data has run out), next-free-buffer (a slot has drained and the channel went on to the other one) and memory error.

Software arms a slot by writing its count and then its address. It watches the state field to see the channel settle after a disable.

Top module: `dbdma_chan`

## Requirements
- R1: After reset every register reads 0, the state is idle (0), `irq` is low, `mem_valid` is low and `per_port` is 0.
- R2: Register offsets: control 0x00, interrupt status 0x04, port select 0x08, status 0x0C, slot 0 count 0x20 and address 0x24, slot 1 count 0x30 and address 0x34.
  - Control has stall enable in bit 0, next-free enable in bit 1, error enable in bit 3, channel enable in bit 4 and a plain storage bit in bit 6. Its other bits read 0.
  - Port select keeps only bits [3:0], which drive `per_port`.
- R3: A write to a slot's address register arms that slot only if the slot is not armed and its count is nonzero. A count of 0 leaves the slot unarmed. While a slot is armed, writes to its count and address registers are ignored.
- R4: In state on or next, `mem_valid` equals `pr_valid` and `pr_ready` equals `mem_ready` for the current slot.
  - Each accepted handshake (`mem_valid` and `mem_ready`) moves one byte at `mem_addr`.
  - After each accepted handshake, the slot's address register increments and its count decrements.
- R5: Status bits [5:4] give the state: idle=0, stall=1, on=2, next=3.
  - When enabled, the state becomes on or next at the clock edge that arms a slot.
  - With the enable off, the idle state is held even if a slot is armed.
- R6: When a slot drains and the other slot is armed, the channel continues on the other slot with no idle cycle. It then sets the next-free flag (interrupt status bit 1). That flag clears when any slot is next armed.
- R7: When a slot drains and no slot is armed, the state becomes stall. Interrupt status bit 0 reads 1 exactly while in stall. Arming a slot while enabled in stall returns the state to on.
- R8: Clearing the enable while on or next does not stop the transfer. Both armed slots drain, then the state passes through stall and becomes idle one edge later.
- R9: A pulse on `mem_err` sets the error flag (interrupt status bit 3) without changing the sequencer. Any write to offset 0x04 clears the error flag, and a new error in the same cycle wins.
- R10: `irq` is the OR of stall flag AND bit 0, next-free flag AND bit 1, and error flag AND bit 3.
- R11: If only the slot that is not current is armed, the channel switches to that slot one cycle later and transfers from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| per_port | output | 4 | Selected peripheral port |
| pr_valid | input | 1 | Peripheral requests a byte transfer |
| pr_ready | output | 1 | Peripheral request accepted this cycle |
| mem_valid | output | 1 | Memory request for one byte |
| mem_ready | input | 1 | Memory accepts the request (back-pressure) |
| mem_addr | output | 32 | Byte address of the memory request |
| mem_err | input | 1 | Memory reported an error |
| irq | output | 1 | Channel interrupt |

## Verification
Register reads are combinational and are taken one time unit after the edge that performed the write. Arming a slot therefore shows its new state in that same read. A disable seen in stall shows idle after one more edge. An out-of-turn slot starts its handshakes one cycle after arming.

The byte handshakes are checked at the falling edge in the cycle where they occur. Each one is compared against an address list the bench computes from each slot's start and count. Back-pressure comes from a three-cycle `mem_ready` pattern. The sweep covers every count pair from 1 to 3 under both full-rate and throttled memory, checking flags, interrupt and final slot registers once stall is reached.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STALL = 2'd1,
    ST_ON    = 2'd2,
    ST_NEXT  = 2'd3
  } ch_state_e;

  localparam int RAW = 6;
  localparam logic [RAW-1:0] OFF_CTRL  = 6'h00;
  localparam logic [RAW-1:0] OFF_INT   = 6'h04;
  localparam logic [RAW-1:0] OFF_PORT  = 6'h08;
  localparam logic [RAW-1:0] OFF_STAT  = 6'h0C;
  localparam logic [RAW-1:0] OFF_CNT0  = 6'h20;
  localparam int SLOT_STRIDE = 16;
  localparam int BASE_GAP    = 4;

  localparam int CB_STALL_IE = 0;
  localparam int CB_NFB_IE   = 1;
  localparam int CB_ERR_IE   = 3;
  localparam int CB_EN       = 4;
  localparam int CB_HOLD     = 6;
  localparam int CTRL_W      = 7;
  localparam logic [CTRL_W-1:0] CTRL_MASK =
    CTRL_W'((1 << CB_STALL_IE) | (1 << CB_NFB_IE) | (1 << CB_ERR_IE) |
            (1 << CB_EN) | (1 << CB_HOLD));
endpackage

// File: rtl/dbdma_slots.sv
module dbdma_slots
  import dbdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [RAW-1:0]       cfg_addr,
  input  logic [DW-1:0]        cfg_wdata,
  input  logic                 act,
  input  logic                 xfer,
  output logic [1:0]           loaded,
  output logic [1:0]           ld_nx,
  output logic [1:0][CW-1:0]   cnt_q,
  output logic [1:0][AW-1:0]   base_q,
  output logic [AW-1:0]        cur_addr,
  output logic                 fin,
  output logic                 arm_any
);
  localparam int NSLOT = 2;
  logic [NSLOT-1:0] arm_v;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [RAW-1:0] CNT_OFF  = OFF_CNT0 + RAW'(k * SLOT_STRIDE);
    localparam logic [RAW-1:0] BASE_OFF = CNT_OFF + RAW'(BASE_GAP);
    logic wr_cnt, wr_base, mv;

    assign wr_cnt   = cfg_we && (cfg_addr == CNT_OFF) && !loaded[k];
    assign wr_base  = cfg_we && (cfg_addr == BASE_OFF) && !loaded[k];
    assign arm_v[k] = wr_base && (cnt_q[k] != '0);
    assign mv       = xfer && (act == 1'(k));
    assign ld_nx[k] = arm_v[k] | (loaded[k] & !(mv && cnt_q[k] == CW'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[k]  <= '0;
        base_q[k] <= '0;
        loaded[k] <= 1'b0;
      end else begin
        if (wr_cnt)       cnt_q[k] <= cfg_wdata[CW-1:0];
        else if (mv)      cnt_q[k] <= cnt_q[k] - CW'(1);
        if (wr_base)      base_q[k] <= cfg_wdata[AW-1:0];
        else if (mv)      base_q[k] <= base_q[k] + AW'(1);
        loaded[k] <= ld_nx[k];
      end
    end

    // R3
    loaded_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loaded[k] |-> cnt_q[k] != '0);
  end

  assign cur_addr = base_q[act];
  assign fin      = xfer && (cnt_q[act] == CW'(1));
  assign arm_any  = |arm_v;
endmodule

// File: rtl/dbdma_seq.sv
module dbdma_seq
  import dbdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] loaded,
  input  logic [1:0] ld_nx,
  input  logic       fin,
  output ch_state_e  state_q,
  output logic       act_q,
  output logic       nfb_set
);
  ch_state_e state_nx, busy_nx;

  assign busy_nx = (ld_nx == 2'b11) ? ST_NEXT : ST_ON;

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_IDLE:  state_nx = (en && |ld_nx) ? busy_nx : ST_IDLE;
      ST_ON,
      ST_NEXT:  state_nx = (|ld_nx) ? busy_nx : ST_STALL;
      ST_STALL: begin
        if (en && |ld_nx) state_nx = busy_nx;
        else if (!en)     state_nx = ST_IDLE;
        else              state_nx = ST_STALL;
      end
      default:  state_nx = ST_IDLE;
    endcase
  end

  assign nfb_set = fin && ld_nx[!act_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      if (fin)                                   act_q <= !act_q;
      else if (!loaded[act_q] && loaded[!act_q]) act_q <= !act_q;
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !en) |=> state_q == ST_IDLE);
  // R6
  next_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_NEXT |-> loaded == 2'b11);
  // R7
  stall_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_STALL |-> loaded == 2'b00);
endmodule

// File: rtl/dbdma_regs.sv
module dbdma_regs
  import dbdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int PW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [RAW-1:0]       cfg_addr,
  input  logic [DW-1:0]        cfg_wdata,
  input  ch_state_e            state,
  input  logic                 nfb_set,
  input  logic                 arm_any,
  input  logic                 mem_err,
  input  logic [1:0][CW-1:0]   cnt_q,
  input  logic [1:0][AW-1:0]   base_q,
  output logic [DW-1:0]        cfg_rdata,
  output logic                 en,
  output logic [PW-1:0]        per_port,
  output logic                 irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              err_q, nfb_q, stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      per_port <= '0;
      err_q    <= 1'b0;
      nfb_q    <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == OFF_CTRL) ctrl_q <= cfg_wdata[CTRL_W-1:0] & CTRL_MASK;
      if (cfg_we && cfg_addr == OFF_PORT) per_port <= cfg_wdata[PW-1:0];
      if (mem_err)                               err_q <= 1'b1;
      else if (cfg_we && cfg_addr == OFF_INT)    err_q <= 1'b0;
      if (nfb_set)      nfb_q <= 1'b1;
      else if (arm_any) nfb_q <= 1'b0;
    end
  end

  assign stall = (state == ST_STALL);
  assign en    = ctrl_q[CB_EN];
  assign irq   = (stall & ctrl_q[CB_STALL_IE]) | (nfb_q & ctrl_q[CB_NFB_IE]) |
                 (err_q & ctrl_q[CB_ERR_IE]);

  always_comb begin
    case (cfg_addr)
      OFF_CTRL:                            cfg_rdata = DW'(ctrl_q);
      OFF_INT:                             cfg_rdata = DW'({err_q, 1'b0, nfb_q, stall});
      OFF_PORT:                            cfg_rdata = DW'(per_port);
      OFF_STAT:                            cfg_rdata = DW'({state, 4'b0000});
      OFF_CNT0:                            cfg_rdata = DW'(cnt_q[0]);
      OFF_CNT0 + RAW'(BASE_GAP):           cfg_rdata = DW'(base_q[0]);
      OFF_CNT0 + RAW'(SLOT_STRIDE):        cfg_rdata = DW'(cnt_q[1]);
      OFF_CNT0 + RAW'(SLOT_STRIDE+BASE_GAP): cfg_rdata = DW'(base_q[1]);
      default:                             cfg_rdata = '0;
    endcase
  end

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_err |=> err_q);
  // R9
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == OFF_INT && !mem_err) |=> !err_q);
endmodule

// File: rtl/dbdma_chan.sv
module dbdma_chan
  import dbdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int PW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [5:0]     cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  output logic [3:0]     per_port,
  input  logic           pr_valid,
  output logic           pr_ready,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [31:0]    mem_addr,
  input  logic           mem_err,
  output logic           irq
);
  ch_state_e            state;
  logic                 act, xfer, fin, arm_any, nfb_set, en, running, go;
  logic [1:0]           loaded, ld_nx;
  logic [1:0][CW-1:0]   cnt_q;
  logic [1:0][AW-1:0]   base_q;
  logic [AW-1:0]        cur_addr;

  assign running   = (state == ST_ON) || (state == ST_NEXT);
  assign go        = running && loaded[act];
  assign mem_valid = go && pr_valid;
  assign pr_ready  = go && mem_ready;
  assign xfer      = mem_valid && mem_ready;
  assign mem_addr  = 32'(cur_addr);

  dbdma_slots #(.AW(AW), .CW(CW), .DW(DW)) u_slots (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .act(act), .xfer(xfer), .loaded(loaded),
    .ld_nx(ld_nx), .cnt_q(cnt_q), .base_q(base_q), .cur_addr(cur_addr),
    .fin(fin), .arm_any(arm_any)
  );

  dbdma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .loaded(loaded), .ld_nx(ld_nx),
    .fin(fin), .state_q(state), .act_q(act), .nfb_set(nfb_set)
  );

  dbdma_regs #(.AW(AW), .CW(CW), .DW(DW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .state(state), .nfb_set(nfb_set),
    .arm_any(arm_any), .mem_err(mem_err), .cnt_q(cnt_q), .base_q(base_q),
    .cfg_rdata(cfg_rdata), .en(en), .per_port(per_port), .irq(irq)
  );

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !fin) |=> mem_addr == $past(mem_addr) + 32'd1);
endmodule

// File: tb/dbdma_chan_test.sv
module dbdma_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  per_port;
  logic        pr_valid = 1'b0;
  logic        pr_ready;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr;
  logic        mem_err = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int exp_addr [0:63];
  int exp_n = 0;
  int got_n = 0;
  int cyc = 0;
  int rdy_pat = 0;
  bit seen_stall = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  dbdma_chan uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .per_port(per_port),
    .pr_valid(pr_valid), .pr_ready(pr_ready), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_err(mem_err), .irq(irq)
  );

  task automatic chk(input string tag, input longint act_v, input longint exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic wait_state(input logic [1:0] s, input int lim);
    logic [31:0] t;
    seen_stall = 0;
    for (int i = 0; i < lim; i++) begin
      rd(6'h0C, t);
      if (t[5:4] == 2'd1) seen_stall = 1;
      if (t[5:4] == s) break;
      @(posedge clk); #1;
    end
  endtask

  task automatic expect_run(input int b, input int n);
    for (int i = 0; i < n; i++) begin
      exp_addr[exp_n] = b + i;
      exp_n++;
    end
  endtask

  // back-pressure pattern
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    mem_ready = (rdy_pat == 0) ? 1'b1 : ((cyc % 3) != 1);
  end

  // handshake monitor: R4 address order and ready pass-through
  always @(negedge clk) begin
    if (rst_n && mem_valid) begin
      chk("R4 pr_ready follows mem_ready", pr_ready, mem_ready);
      if (mem_ready) begin
        if (got_n < exp_n) chk("R4 byte address", mem_addr, exp_addr[got_n]);
        else               chk("R4 unexpected transfer", got_n, exp_n);
        got_n++;
      end
    end
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    pr_valid = 1'b1;
    #1;
    // R1 reset state
    rd(6'h00, v); chk("R1 control", v, 0);
    rd(6'h04, v); chk("R1 int status", v, 0);
    rd(6'h0C, v); chk("R1 status", v, 0);
    rd(6'h24, v); chk("R1 slot0 address", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 per_port", per_port, 0);
    pr_valid = 1'b0;

    // R2 field masks and port select
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, v); chk("R2 control mask", v, 32'h5B);
    rd(6'h0C, v); chk("R5 idle with no slot", v[5:4], 0);
    wr(6'h08, 32'hAB);
    rd(6'h08, v); chk("R2 port readback", v, 32'hB);
    chk("R2 per_port pin", per_port, 4'hB);
    wr(6'h00, 32'h0);

    // R3 arming rules
    wr(6'h00, 32'h10);
    wr(6'h20, 0); wr(6'h24, 32'h100);
    rd(6'h0C, v); chk("R3 zero count not armed", v[5:4], 0);
    wr(6'h20, 2); wr(6'h24, 32'h100);
    rd(6'h0C, v); chk("R5 on at arm edge", v[5:4], 2);
    wr(6'h20, 7);
    rd(6'h20, v); chk("R3 count write ignored when armed", v, 2);
    wr(6'h24, 32'h555);
    rd(6'h24, v); chk("R3 address write ignored when armed", v, 32'h100);
    exp_n = 0; got_n = 0; expect_run(32'h100, 2);
    pr_valid = 1'b1;
    wait_state(2'd1, 50);
    chk("R7 bytes before stall", got_n, 2);
    rd(6'h04, v); chk("R7 stall flag", v, 1);
    chk("R10 irq masked", irq, 0);
    wr(6'h00, 32'h11);
    chk("R10 irq stall enabled", irq, 1);
    pr_valid = 1'b0;
    wr(6'h30, 1); wr(6'h34, 32'h200);
    rd(6'h0C, v); chk("R7 stall to on on arm", v[5:4], 2);
    exp_n = 0; got_n = 0; expect_run(32'h200, 1);
    pr_valid = 1'b1;
    wait_state(2'd1, 50);
    chk("R7 second run bytes", got_n, 1);
    pr_valid = 1'b0;
    wr(6'h00, 32'h0);
    rd(6'h0C, v); chk("R8 still stall at disable edge", v[5:4], 1);
    @(posedge clk); #1;
    rd(6'h0C, v); chk("R8 idle one edge later", v[5:4], 0);

    // R11 out-of-turn slot
    wr(6'h00, 32'h10);
    wr(6'h30, 2); wr(6'h34, 32'h300);
    rd(6'h0C, v); chk("R11 on with other slot", v[5:4], 2);
    exp_n = 0; got_n = 0; expect_run(32'h300, 2);
    pr_valid = 1'b1;
    wait_state(2'd1, 50);
    chk("R11 bytes from other slot", got_n, 2);
    pr_valid = 1'b0;
    wr(6'h00, 32'h0);
    wait_state(2'd0, 10);

    // R9 error flag and R10
    wr(6'h00, 32'h18);
    chk("R10 irq before error", irq, 0);
    @(negedge clk); mem_err = 1'b1;
    @(posedge clk); #1; mem_err = 1'b0;
    rd(6'h04, v); chk("R9 error flag", v, 8);
    chk("R10 irq on error", irq, 1);
    rd(6'h0C, v); chk("R9 sequencer unaffected", v[5:4], 0);
    wr(6'h04, 32'h0);
    rd(6'h04, v); chk("R9 error cleared", v, 0);
    chk("R10 irq after clear", irq, 0);

    // R8 disable while both slots armed
    wr(6'h00, 32'h13);
    wr(6'h20, 3); wr(6'h24, 32'h400);
    wr(6'h30, 2); wr(6'h34, 32'h500);
    rd(6'h0C, v); chk("R5 next with both slots", v[5:4], 3);
    wr(6'h00, 32'h03);
    rd(6'h0C, v); chk("R8 next kept after disable", v[5:4], 3);
    exp_n = 0; got_n = 0; expect_run(32'h400, 3); expect_run(32'h500, 2);
    pr_valid = 1'b1;
    wait_state(2'd0, 60);
    rd(6'h0C, v); chk("R8 idle after drain", v[5:4], 0);
    chk("R8 passed through stall", seen_stall, 1);
    chk("R8 all bytes moved", got_n, 5);
    rd(6'h04, v); chk("R6 next-free flag", v, 2);
    chk("R10 irq next-free", irq, 1);
    pr_valid = 1'b0;
    wr(6'h20, 1); wr(6'h24, 32'h600);
    rd(6'h04, v); chk("R6 flag cleared by arm", v, 0);
    rd(6'h0C, v); chk("R5 idle while disabled", v[5:4], 0);
    wr(6'h00, 32'h10);
    exp_n = 0; got_n = 0; expect_run(32'h600, 1);
    pr_valid = 1'b1;
    wait_state(2'd1, 50);
    chk("R5 start after enable", got_n, 1);
    pr_valid = 1'b0;
    wr(6'h00, 32'h0);
    wait_state(2'd0, 10);

    // sweep of count pairs under two ready patterns
    for (int pat = 0; pat < 2; pat++) begin
      for (int c0 = 1; c0 <= 3; c0++) begin
        for (int c1 = 1; c1 <= 3; c1++) begin
          int b0, b1;
          b0 = 32'h1000 + pat * 32'h400 + c0 * 32'h40 + c1 * 8;
          b1 = 32'h8000 + pat * 32'h400 + c0 * 32'h40 + c1 * 8;
          rdy_pat = pat;
          wr(6'h00, 32'h13);
          wr(6'h20, c0); wr(6'h24, b0);
          rd(6'h04, v); chk("R6 flag clear after arm", v[1], 0);
          wr(6'h30, c1); wr(6'h34, b1);
          rd(6'h0C, v); chk("R5 next state", v[5:4], 3);
          exp_n = 0; got_n = 0; expect_run(b0, c0); expect_run(b1, c1);
          pr_valid = 1'b1;
          wait_state(2'd1, 100);
          pr_valid = 1'b0;
          chk("R6 continuous bytes", got_n, c0 + c1);
          rd(6'h04, v); chk("R7 stall and next-free flags", v, 3);
          chk("R10 irq in sweep", irq, 1);
          rd(6'h20, v); chk("R4 slot0 count drained", v, 0);
          rd(6'h24, v); chk("R4 slot0 address advanced", v, b0 + c0);
          rd(6'h34, v); chk("R4 slot1 address advanced", v, b1 + c1);
          wr(6'h00, 32'h0);
          wait_state(2'd0, 10);
        end
      end
    end
    rdy_pat = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule